// File: doc/BRIEF.md
# Power-Up and Brown-Out Reset Sequencer

This block keeps the processor core in reset after a power-on event, while the external reset pin is held, and during a supply brown-out, and releases it only once the clocks can be trusted. After power-on it runs up to three delays in a fixed order. The first is a power-up delay counted in ticks of the internal slow oscillator. The second is an oscillator start-up delay counted in main-clock cycles, used only by crystal-type modes. The third is a PLL lock delay counted in slow ticks, used only in the PLL mode. The slow oscillator reaches the block as a one-cycle tick enable in the main clock domain.

The brown-out comparator flag is accepted only after it has stayed high for a set number of slow ticks. Whether it is accepted at all depends on a two-bit brown-out mode and, in some modes, on a software enable bit or on sleep status. After the supply recovers, only the power-up delay runs again. Two sticky status flags record power-on and brown-out events, and software sets them back to 1.

Top module: `pwr_reset_seq`

## Requirements
- R1: After the power-on pulse ends, the block runs three delays in this order. The power-up delay lasts PUT_TICKS slow ticks and runs only when `cfg_put_off_i` is 0. The start-up delay lasts OST_CYCLES clock cycles and runs for oscillator modes 0 (low-power crystal), 1 (crystal), 2 (high-speed) and 3 (high-speed with PLL). The lock delay lasts PLL_TICKS slow ticks and runs only in mode 3. `core_rst_o` stays 1 until every delay that applies has expired.
- R2: In modes 4 (RC) and 5 (external clock) with `cfg_put_off_i` = 1, no delay runs, and `core_rst_o` falls within 4 cycles of the end of the power-on pulse.
- R3: `ext_rst_ni` passes through a 2-flop synchroniser. While it is low, `core_rst_o` is 1, but the power-on delays still run. When it is released after those delays have expired, `core_rst_o` falls within 4 cycles.
- R4: A brown-out is accepted once `bor_cmp_i` has been high for BOR_FILT_TICKS consecutive slow ticks while detection is enabled. A shorter pulse has no effect. An accepted brown-out drives `core_rst_o` to 1 from the next cycle and holds it there while the comparator stays high.
- R5: When the comparator falls after an accepted brown-out, only the power-up delay runs (if enabled), and then the reset is released. A brown-out accepted during that delay restarts it from zero.
- R6: Brown-out mode `cfg_bor_mode_i` works as follows: 00 means detection is off, 01 follows `sw_bor_en_i`, 10 means detection is on except while `sleep_i` is 1, and 11 means always on.
- R7: `sw_bor_en_rd_o` equals `sw_bor_en_i` in mode 01 and reads 0 in every other mode.
- R8: `por_flag_o` is 0 after a power-on pulse. It becomes 1 only through `sw_por_set_i` and is not changed by a brown-out.
- R9: `bor_flag_o` is 0 after a power-on pulse and is cleared by any accepted brown-out. It becomes 1 only through `sw_bor_set_i`.
- R10: While `por_i` is 1, `core_rst_o` is 1 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| slow_tick_i | input | 1 | One-cycle tick from the internal slow oscillator |
| ext_rst_ni | input | 1 | External reset, active low, asynchronous to the block |
| bor_cmp_i | input | 1 | Supply-below-threshold flag from the comparator |
| sleep_i | input | 1 | Core is in sleep |
| cfg_put_off_i | input | 1 | 1 disables the power-up delay |
| cfg_osc_mode_i | input | 3 | Oscillator mode code (0..5, see R1/R2) |
| cfg_bor_mode_i | input | 2 | Brown-out mode (see R6) |
| sw_bor_en_i | input | 1 | Software brown-out enable |
| sw_por_set_i | input | 1 | Software sets the power-on flag |
| sw_bor_set_i | input | 1 | Software sets the brown-out flag |
| core_rst_o | output | 1 | Core reset, active high |
| por_flag_o | output | 1 | Power-on status flag |
| bor_flag_o | output | 1 | Brown-out status flag |
| sw_bor_en_rd_o | output | 1 | Read-back of the software brown-out enable |

## Verification
The bench measures how long the core stays in reset after power-on for every oscillator mode, with the power-up delay both on and off. A design that skipped the start-up or lock delay, or ran the power-up delay with the enable sense inverted, would release the core tens of cycles away from the expected window. A second brown-out is raised halfway through the recovery delay. A design that let the delay carry on would release the core about half a delay early. The bench also sends comparator pulses one tick shorter than the filter, exercises each brown-out mode with its qualifier both set and clear, and holds the external reset across the whole power-on chain. A filter that was too eager, a mode decoded the wrong way, or delays that waited for the external reset would each change when `core_rst_o` falls.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        OSC_LP    = 3'd0,
        OSC_XT    = 3'd1,
        OSC_HS    = 3'd2,
        OSC_HSPLL = 3'd3,
        OSC_RC    = 3'd4,
        OSC_EC    = 3'd5
    } osc_mode_e;

    typedef enum logic [1:0] {
        BRN_OFF     = 2'b00,
        BRN_SW      = 2'b01,
        BRN_NOSLEEP = 2'b10,
        BRN_ON      = 2'b11
    } brn_mode_e;

    typedef enum logic [2:0] {
        SEQ_START = 3'd0,
        SEQ_PUT   = 3'd1,
        SEQ_OST   = 3'd2,
        SEQ_PLL   = 3'd3,
        SEQ_RUN   = 3'd4,
        SEQ_BROWN = 3'd5
    } seq_state_e;

    function automatic logic mode_needs_ost(input logic [2:0] m);
        return (m == OSC_LP) || (m == OSC_XT) || (m == OSC_HS) || (m == OSC_HSPLL);
    endfunction

    function automatic logic mode_needs_pll(input logic [2:0] m);
        return (m == OSC_HSPLL);
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic din_i,
    output logic dout_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign dout_o = r_q.sh[STAGES-1];
endmodule

// File: rtl/rstseq_bor_gate.sv
module rstseq_bor_gate
    import rstseq_pkg::*;
#(
    parameter int FILT_TICKS = 4
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       tick_i,
    input  logic       cmp_i,
    input  logic [1:0] mode_i,
    input  logic       sleep_i,
    input  logic       sw_en_i,
    output logic       brown_o,
    output logic       sw_en_rd_o
);
    localparam int FW = $clog2(FILT_TICKS + 1);
    localparam logic [FW-1:0] FILT_LAST = FW'(FILT_TICKS - 1);

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          active;
    } gate_t;

    gate_t r_d, r_q;
    logic  det_en_d;

    always_comb begin
        case (brn_mode_e'(mode_i))
            BRN_OFF:     det_en_d = 1'b0;
            BRN_SW:      det_en_d = sw_en_i;
            BRN_NOSLEEP: det_en_d = ~sleep_i;
            default:     det_en_d = 1'b1;
        endcase

        r_d = r_q;
        if (!det_en_d || !cmp_i) begin
            r_d.cnt    = '0;
            r_d.active = 1'b0;
        end else if (!r_q.active && tick_i) begin
            if (r_q.cnt == FILT_LAST) begin
                r_d.active = 1'b1;
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt + FW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign brown_o    = r_q.active;
    assign sw_en_rd_o = (brn_mode_e'(mode_i) == BRN_SW) ? sw_en_i : 1'b0;
endmodule

// File: rtl/rstseq_timeout.sv
module rstseq_timeout
    import rstseq_pkg::*;
#(
    parameter int PUT_TICKS  = 2048,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 64
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       tick_i,
    input  logic       brown_i,
    input  logic       put_off_i,
    input  logic [2:0] osc_mode_i,
    output logic       done_o
);
    localparam int M1   = (PUT_TICKS > OST_CYCLES) ? PUT_TICKS : OST_CYCLES;
    localparam int MAXC = (M1 > PLL_TICKS) ? M1 : PLL_TICKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PUT_LAST = CW'(PUT_TICKS - 1);
    localparam logic [CW-1:0] OST_LAST = CW'(OST_CYCLES - 1);
    localparam logic [CW-1:0] PLL_LAST = CW'(PLL_TICKS - 1);

    typedef struct packed {
        seq_state_e    st;
        logic          warm;
        logic [CW-1:0] cnt;
    } tmo_t;

    tmo_t       r_d, r_q;
    seq_state_e after_put_d;
    logic       pll_on_d;

    always_comb begin
        pll_on_d    = mode_needs_pll(osc_mode_i);
        after_put_d = mode_needs_ost(osc_mode_i) ? SEQ_OST :
                      (pll_on_d ? SEQ_PLL : SEQ_RUN);

        r_d = r_q;
        if (brown_i) begin
            r_d.st   = SEQ_BROWN;
            r_d.cnt  = '0;
            r_d.warm = 1'b1;
        end else begin
            case (r_q.st)
                SEQ_START: begin
                    r_d.st = put_off_i ? after_put_d : SEQ_PUT;
                end
                SEQ_PUT: begin
                    if (tick_i) begin
                        if (r_q.cnt == PUT_LAST) begin
                            r_d.cnt = '0;
                            r_d.st  = r_q.warm ? SEQ_RUN : after_put_d;
                        end else begin
                            r_d.cnt = r_q.cnt + CW'(1);
                        end
                    end
                end
                SEQ_OST: begin
                    if (r_q.cnt == OST_LAST) begin
                        r_d.cnt = '0;
                        r_d.st  = pll_on_d ? SEQ_PLL : SEQ_RUN;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
                SEQ_PLL: begin
                    if (tick_i) begin
                        if (r_q.cnt == PLL_LAST) begin
                            r_d.cnt = '0;
                            r_d.st  = SEQ_RUN;
                        end else begin
                            r_d.cnt = r_q.cnt + CW'(1);
                        end
                    end
                end
                SEQ_BROWN: begin
                    r_d.cnt = '0;
                    r_d.st  = put_off_i ? SEQ_RUN : SEQ_PUT;
                end
                default: r_d.st = SEQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) r_q <= '{st: SEQ_START, warm: 1'b0, cnt: '0};
        else       r_q <= r_d;
    end

    assign done_o = (r_q.st == SEQ_RUN);
endmodule

// File: rtl/pwr_reset_seq.sv
module pwr_reset_seq
    import rstseq_pkg::*;
#(
    parameter int PUT_TICKS      = 2048,
    parameter int OST_CYCLES     = 1024,
    parameter int PLL_TICKS      = 64,
    parameter int BOR_FILT_TICKS = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       slow_tick_i,
    input  logic       ext_rst_ni,
    input  logic       bor_cmp_i,
    input  logic       sleep_i,
    input  logic       cfg_put_off_i,
    input  logic [2:0] cfg_osc_mode_i,
    input  logic [1:0] cfg_bor_mode_i,
    input  logic       sw_bor_en_i,
    input  logic       sw_por_set_i,
    input  logic       sw_bor_set_i,
    output logic       core_rst_o,
    output logic       por_flag_o,
    output logic       bor_flag_o,
    output logic       sw_bor_en_rd_o
);
    typedef struct packed {
        logic core_rst;
        logic por_flag;
        logic bor_flag;
    } top_t;

    logic ext_ok;
    logic brown;
    logic tmo_done;
    top_t r_d, r_q;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .por_i  (por_i),
        .din_i  (ext_rst_ni),
        .dout_o (ext_ok)
    );

    rstseq_bor_gate #(.FILT_TICKS(BOR_FILT_TICKS)) u_gate (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .tick_i     (slow_tick_i),
        .cmp_i      (bor_cmp_i),
        .mode_i     (cfg_bor_mode_i),
        .sleep_i    (sleep_i),
        .sw_en_i    (sw_bor_en_i),
        .brown_o    (brown),
        .sw_en_rd_o (sw_bor_en_rd_o)
    );

    rstseq_timeout #(
        .PUT_TICKS  (PUT_TICKS),
        .OST_CYCLES (OST_CYCLES),
        .PLL_TICKS  (PLL_TICKS)
    ) u_tmo (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .tick_i     (slow_tick_i),
        .brown_i    (brown),
        .put_off_i  (cfg_put_off_i),
        .osc_mode_i (cfg_osc_mode_i),
        .done_o     (tmo_done)
    );

    always_comb begin
        r_d          = r_q;
        r_d.core_rst = ~tmo_done | ~ext_ok | brown;
        if (sw_por_set_i) r_d.por_flag = 1'b1;
        if (brown)             r_d.bor_flag = 1'b0;
        else if (sw_bor_set_i) r_d.bor_flag = 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) r_q <= '{core_rst: 1'b1, por_flag: 1'b0, bor_flag: 1'b0};
        else       r_q <= r_d;
    end

    assign core_rst_o = r_q.core_rst;
    assign por_flag_o = r_q.por_flag;
    assign bor_flag_o = r_q.bor_flag;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic       clk_i,
    input logic       por_i,
    input logic       ext_ok_i,
    input logic       brown_i,
    input logic       tmo_done_i,
    input logic [1:0] bor_mode_i,
    input logic       sw_por_set_i,
    input logic       sw_bor_set_i,
    input logic       core_rst_i,
    input logic       por_flag_i,
    input logic       bor_flag_i
);
    // R1
    tmo_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !tmo_done_i |=> core_rst_i);

    // R3
    ext_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !ext_ok_i |=> core_rst_i);

    // R4
    brown_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
        brown_i |=> core_rst_i);

    // R6
    brown_off_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (bor_mode_i == 2'b00) |-> !brown_i);

    // R8
    por_set_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(por_flag_i) |-> $past(sw_por_set_i));

    // R9
    bor_clr_chk: assert property (@(posedge clk_i) disable iff (por_i)
        brown_i |=> !bor_flag_i);

    // R9
    bor_set_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(bor_flag_i) |-> $past(sw_bor_set_i));
endmodule

bind pwr_reset_seq rstseq_chk u_chk (
    .clk_i        (clk_i),
    .por_i        (por_i),
    .ext_ok_i     (ext_ok),
    .brown_i      (brown),
    .tmo_done_i   (tmo_done),
    .bor_mode_i   (cfg_bor_mode_i),
    .sw_por_set_i (sw_por_set_i),
    .sw_bor_set_i (sw_bor_set_i),
    .core_rst_i   (core_rst_o),
    .por_flag_i   (por_flag_o),
    .bor_flag_i   (bor_flag_o)
);

// File: tb/test_pwr_reset_seq.sv
module test_pwr_reset_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TP    = 4;
    localparam int PUT_T = 8;
    localparam int OST_C = 12;
    localparam int PLL_T = 5;
    localparam int FILT  = 3;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_n = 1'b1;
    logic       cmp = 1'b0;
    logic       sleep = 1'b0;
    logic       put_off = 1'b0;
    logic [2:0] osc = 3'd1;
    logic [1:0] bmode = 2'b00;
    logic       sw_en = 1'b0;
    logic       sw_pset = 1'b0;
    logic       sw_bset = 1'b0;
    logic       core_rst, por_flag, bor_flag, sw_rd;
    logic       tick;
    int         tcnt = 0;
    int         cyc = 0;
    int         total = 0;
    int         bad = 0;
    bit         ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (por) tcnt = 0;
        else     tcnt = (tcnt == TP-1) ? 0 : tcnt + 1;
    end
    assign tick = (tcnt == TP-1) && !por;

    pwr_reset_seq #(
        .PUT_TICKS(PUT_T), .OST_CYCLES(OST_C), .PLL_TICKS(PLL_T),
        .BOR_FILT_TICKS(FILT), .SYNC_STAGES(2)
    ) i_pwr_reset_seq (
        .clk_i(clk), .por_i(por), .slow_tick_i(tick), .ext_rst_ni(ext_n),
        .bor_cmp_i(cmp), .sleep_i(sleep), .cfg_put_off_i(put_off),
        .cfg_osc_mode_i(osc), .cfg_bor_mode_i(bmode), .sw_bor_en_i(sw_en),
        .sw_por_set_i(sw_pset), .sw_bor_set_i(sw_bset),
        .core_rst_o(core_rst), .por_flag_o(por_flag), .bor_flag_o(bor_flag),
        .sw_bor_en_rd_o(sw_rd)
    );

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int cold_exp(input int m, input bit off);
        int e = 0;
        if (!off) e += PUT_T * TP;
        if (m <= 3) e += OST_C;
        if (m == 3) e += PLL_T * TP;
        return e;
    endfunction

    task automatic measure(output int n);
        n = 0;
        while (core_rst && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_win(input int n, input int e, input string req);
        int lo = (e > 2*TP) ? e - 2*TP : 0;
        check(n >= lo && n <= e + 2*TP + 6, req, n, e);
    endtask

    task automatic pulse_por();
        @(negedge clk); por = 1'b1;
        wait_cyc(3);
        por = 1'b0;
    endtask

    task automatic cold(input int m, input bit off, input string req);
        int n;
        osc = 3'(m); put_off = off;
        pulse_por();
        measure(n);
        if (m >= 4 && off) check(n <= 4, req, n, 4);
        else               check_win(n, cold_exp(m, off), req);
    endtask

    task automatic pulse_sw(input bit which);
        @(negedge clk);
        if (which) sw_pset = 1'b1; else sw_bset = 1'b1;
        @(negedge clk);
        sw_pset = 1'b0; sw_bset = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        wait_cyc(4);
        // R10: reset state while the pulse is present
        check(core_rst == 1'b1, "R10 core_rst", core_rst, 1);
        check(por_flag == 1'b0, "R10 por_flag", por_flag, 0);
        check(bor_flag == 1'b0, "R10 bor_flag", bor_flag, 0);
        por = 1'b0;
        measure(n);
        check_win(n, cold_exp(1, 0), "R1 xt put");

        // R1: directed chains
        cold(3, 0, "R1 hspll put");
        cold(3, 1, "R1 hspll noput");
        cold(4, 0, "R1 rc put");
        cold(0, 1, "R1 lp noput");
        // R2: no delay at all
        cold(4, 1, "R2 rc");
        cold(5, 1, "R2 ec");

        // R3: delays run under external reset
        ext_n = 1'b0; osc = 3'd4; put_off = 1'b0;
        pulse_por();
        wait_cyc(PUT_T*TP + 40);
        check(core_rst == 1'b1, "R3 held", core_rst, 1);
        ext_n = 1'b1;
        measure(n);
        check(n <= 4, "R3 release", n, 4);

        // R8 / R9 software sets
        check(por_flag == 1'b0, "R8 after por", por_flag, 0);
        pulse_sw(1'b1);
        check(por_flag == 1'b1, "R8 sw set", por_flag, 1);
        pulse_sw(1'b0);
        check(bor_flag == 1'b1, "R9 sw set", bor_flag, 1);

        // R4: short pulse ignored, long one accepted (mode 11)
        bmode = 2'b11;
        @(negedge clk); cmp = 1'b1;
        wait_cyc(TP + 1);
        cmp = 1'b0;
        wait_cyc(4);
        check(core_rst == 1'b0, "R4 glitch", core_rst, 0);
        check(bor_flag == 1'b1, "R4 glitch flag", bor_flag, 1);
        cmp = 1'b1;
        wait_cyc((FILT + 2) * TP);
        check(core_rst == 1'b1, "R4 accepted", core_rst, 1);
        check(bor_flag == 1'b0, "R9 bor clears", bor_flag, 0);
        check(por_flag == 1'b1, "R8 kept", por_flag, 1);
        cmp = 1'b0;
        measure(n);
        // R5: only the power-up delay after recovery
        check_win(n, PUT_T * TP, "R5 recover");

        // R5: brown-out during the delay restarts it
        cmp = 1'b1; wait_cyc((FILT + 2) * TP);
        cmp = 1'b0; wait_cyc(PUT_T * TP / 2);
        cmp = 1'b1; wait_cyc((FILT + 1) * TP + 2);
        check(core_rst == 1'b1, "R5 re-brown", core_rst, 1);
        cmp = 1'b0;
        measure(n);
        check_win(n, PUT_T * TP, "R5 restart");

        // R6/R7 mode 00
        bmode = 2'b00; sw_en = 1'b1;
        @(negedge clk);
        check(sw_rd == 1'b0, "R7 mode00", sw_rd, 0);
        cmp = 1'b1; wait_cyc((FILT + 3) * TP);
        check(core_rst == 1'b0, "R6 mode00", core_rst, 0);
        cmp = 1'b0;
        // mode 11 read-back
        bmode = 2'b11; @(negedge clk);
        check(sw_rd == 1'b0, "R7 mode11", sw_rd, 0);

        // R6/R7 mode 01
        bmode = 2'b01; sw_en = 1'b0; @(negedge clk);
        check(sw_rd == 1'b0, "R7 mode01 off", sw_rd, 0);
        cmp = 1'b1; wait_cyc((FILT + 3) * TP);
        check(core_rst == 1'b0, "R6 mode01 off", core_rst, 0);
        sw_en = 1'b1; @(negedge clk);
        check(sw_rd == 1'b1, "R7 mode01 on", sw_rd, 1);
        wait_cyc((FILT + 2) * TP);
        check(core_rst == 1'b1, "R6 mode01 on", core_rst, 1);
        cmp = 1'b0; measure(n);

        // R6 mode 10
        bmode = 2'b10; sleep = 1'b1;
        cmp = 1'b1; wait_cyc((FILT + 3) * TP);
        check(core_rst == 1'b0, "R6 mode10 sleep", core_rst, 0);
        sleep = 1'b0; wait_cyc((FILT + 2) * TP);
        check(core_rst == 1'b1, "R6 mode10 awake", core_rst, 1);
        cmp = 1'b0; measure(n);
        bmode = 2'b00;

        // R8: a new power-on clears the flag
        cold(2, 0, "R1 hs put");
        check(por_flag == 1'b0, "R8 new por", por_flag, 0);

        // R1/R2: random configurations
        for (int k = 0; k < 12; k++) begin
            int m = int'($urandom_range(0, 5));
            bit off = 1'($urandom_range(0, 1));
            cold(m, off, (m >= 4 && off) ? "R2 random" : "R1 random");
        end

        summary();
    end
endmodule